// File: doc/BRIEF.md
# Selectable-Rate Timer Tick Generator

This block turns one fast system clock into increment enables for three timer/counters. Each timer can run at a legacy rate, with one enable every 12 system clocks, or at a fast rate, with one enable every 4 clocks. The rate is picked per timer at run time through one clock-control register. That register sits at a single address on a special-function-register write/read port.

A timer in counter mode does not take the internal tick. Its enable comes instead from falling edges on its external event input, which the block synchronises first. Timer 2 also has a baud-rate generation mode. In that mode its rate-select bit is overridden and it stays at the legacy rate. The low three bits of the register are a plain storage field that reads back as written. The timers, reload and interrupt logic live in neighbouring blocks.

Top module: `timer_tick_gen`

## Requirements
- R1: A timer in timer mode whose select bit is 0 receives exactly one tick every 12 system clocks.
- R2: A timer in timer mode whose select bit is 1 receives exactly one tick every 4 system clocks.
- R3: The control register answers only at address 0x8E. Bit 3 selects the rate of timer 0, bit 4 that of timer 1 and bit 5 that of timer 2. Bits 2..0 are stored and read back unchanged. Read data is registered and appears one clock after the address. A write to any other address leaves the register unchanged.
- R4: The select bits are independent: changing one timer's select leaves the tick spacing of the other timers unchanged.
- R5: After reset, all ticks are 0, all register bits are 0 and every timer runs at the 12-clock rate.
- R6: While a timer's counter-mode input is 1, it gets no internal ticks, whatever its select bit holds. Each falling edge of its external input, sampled through a synchroniser, yields exactly one tick.
- R7: While the baud-rate input is 1, timer 2 ticks every 12 clocks even if bit 5 is 1.
- R8: Bits 7 and 6 of the register always read 0, and writing them has no effect.
- R9: A rate change takes effect at the next tick boundary. The interval already in progress completes at the old rate, and no tick is lost or added.
- R10: Every tick is a single-clock pulse; no tick output is high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register port address |
| sfr_wr | input | 1 | Write strobe for the register port |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Registered read data (0 when the address does not match) |
| cnt_mode | input | 3 | Per-timer counter-mode flag |
| t2_baud | input | 1 | Timer 2 is in baud-rate generation mode |
| ext_evt | input | 3 | Per-timer external event inputs (asynchronous) |
| tick | output | 3 | Per-timer single-cycle increment enables |

## Verification
The bench builds the block with its default parameters: a 12/4 rate pair, a two-stage synchroniser and the register at 0x8E. With only 12 clocks per slow interval, one short run can measure many whole intervals on every timer. That includes the interval that straddles a rate write, which shows that the boundary rule holds. The short synchroniser keeps edge-counting windows to a few clocks. Counter-mode pulse trains and baud-mode overrides can therefore be checked tick by tick at the outputs.

// File: rtl/ttg_pkg.sv
package ttg_pkg;
  localparam int SFR_W      = 8;
  localparam int SEL_LSB    = 3;
  localparam int MD_W       = 3;
  localparam int BAUD_TIMER = 2;
endpackage

// File: rtl/ttg_rate_div.sv
module ttg_rate_div #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_sel,
  output logic pulse
);
  localparam int CW = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt;

  // The down-counter reloads only when it hits zero, so a new select is
  // picked up at the next boundary and the running interval is preserved.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(SLOW_DIV - 1);
    end else if (cnt == '0) begin
      cnt <= fast_sel ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign pulse = (cnt == '0);
endmodule

// File: rtl/ttg_fall_det.sv
module ttg_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/ttg_ctrl_reg.sv
module ttg_ctrl_reg
  import ttg_pkg::*;
#(
  parameter int                 NUM_TIMERS = 3,
  parameter int                 ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR  = 8'h8E
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     sfr_addr,
  input  logic                  sfr_wr,
  input  logic [SFR_W-1:0]      sfr_wdata,
  output logic [SFR_W-1:0]      sfr_rdata,
  output logic [NUM_TIMERS-1:0] fast_sel
);
  logic [MD_W-1:0] md_q;
  logic            hit;
  logic [SFR_W-1:0] rd_img;
  logic            unused_resv;

  assign hit         = (sfr_addr == CTRL_ADDR);
  assign unused_resv = ^sfr_wdata[SFR_W-1:SEL_LSB+NUM_TIMERS];

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_sel <= '0;
      md_q     <= '0;
    end else if (sfr_wr && hit) begin
      fast_sel <= sfr_wdata[SEL_LSB +: NUM_TIMERS];
      md_q     <= sfr_wdata[MD_W-1:0];
    end
  end

  always_comb begin
    rd_img                        = '0;
    rd_img[SEL_LSB +: NUM_TIMERS] = fast_sel;
    rd_img[MD_W-1:0]              = md_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sfr_rdata <= '0;
    else     sfr_rdata <= hit ? rd_img : '0;
  end
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import ttg_pkg::*;
#(
  parameter int                NUM_TIMERS  = 3,
  parameter int                SLOW_DIV    = 12,
  parameter int                FAST_DIV    = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h8E
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     sfr_addr,
  input  logic                  sfr_wr,
  input  logic [SFR_W-1:0]      sfr_wdata,
  output logic [SFR_W-1:0]      sfr_rdata,
  input  logic [NUM_TIMERS-1:0] cnt_mode,
  input  logic                  t2_baud,
  input  logic [NUM_TIMERS-1:0] ext_evt,
  output logic [NUM_TIMERS-1:0] tick
);
  logic [NUM_TIMERS-1:0] fast_sel;
  logic [NUM_TIMERS-1:0] eff_fast;
  logic [NUM_TIMERS-1:0] div_pulse;
  logic [NUM_TIMERS-1:0] evt_fall;

  ttg_ctrl_reg #(
    .NUM_TIMERS(NUM_TIMERS),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_reg (
    .clk      (clk),
    .rst      (rst),
    .sfr_addr (sfr_addr),
    .sfr_wr   (sfr_wr),
    .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata),
    .fast_sel (fast_sel)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    if (i == BAUD_TIMER) begin : g_baud
      assign eff_fast[i] = fast_sel[i] & ~t2_baud;
    end else begin : g_plain
      assign eff_fast[i] = fast_sel[i];
    end

    ttg_rate_div #(
      .SLOW_DIV(SLOW_DIV),
      .FAST_DIV(FAST_DIV)
    ) u_div (
      .clk     (clk),
      .rst     (rst),
      .fast_sel(eff_fast[i]),
      .pulse   (div_pulse[i])
    );

    ttg_fall_det #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
      .clk (clk),
      .rst (rst),
      .din (ext_evt[i]),
      .fall(evt_fall[i])
    );

    always_ff @(posedge clk) begin
      if (rst) tick[i] <= 1'b0;
      else     tick[i] <= cnt_mode[i] ? evt_fall[i] : div_pulse[i];
    end
  end
endmodule

// File: rtl/ttg_checker.sv
module ttg_checker
  import ttg_pkg::*;
#(
  parameter int                NUM_TIMERS  = 3,
  parameter int                SLOW_DIV    = 12,
  parameter int                FAST_DIV    = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h8E
) (
  input logic                  clk,
  input logic                  rst,
  input logic [ADDR_W-1:0]     sfr_addr,
  input logic                  sfr_wr,
  input logic [SFR_W-1:0]      sfr_wdata,
  input logic [SFR_W-1:0]      sfr_rdata,
  input logic [NUM_TIMERS-1:0] cnt_mode,
  input logic                  t2_baud,
  input logic [NUM_TIMERS-1:0] ext_evt,
  input logic [NUM_TIMERS-1:0] tick
);
  localparam int GW = $clog2(SLOW_DIV) + 2;

  logic [GW-1:0]         gap [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] have_prev, clean, cm_d;
  logic                  baud_d, baud_ok;
  logic [SFR_W-1:0]      wd_q;
  logic                  wmatch;

  assign wmatch = sfr_wr && (sfr_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_d    <= '0;
      baud_d  <= 1'b0;
      baud_ok <= 1'b0;
      wd_q    <= '0;
    end else begin
      cm_d   <= cnt_mode;
      baud_d <= t2_baud;
      if (tick[BAUD_TIMER]) baud_ok <= t2_baud && baud_d;
      else if (!t2_baud)    baud_ok <= 1'b0;
      if (wmatch) wd_q <= sfr_wdata & SFR_W'(8'h3F);
    end
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_gap
    always_ff @(posedge clk) begin
      if (rst) begin
        gap[i]       <= '0;
        have_prev[i] <= 1'b0;
        clean[i]     <= 1'b0;
      end else if (tick[i]) begin
        gap[i]       <= GW'(1);
        have_prev[i] <= 1'b1;
        clean[i]     <= !cnt_mode[i] && !cm_d[i];
      end else begin
        if (gap[i] != '1) gap[i] <= gap[i] + 1'b1;
        if (cnt_mode[i])  clean[i] <= 1'b0;
      end
    end

    // R10: single-cycle enable pulses
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
      tick[i] |=> !tick[i]);

    // R1 / R2 / R9: timer-mode ticks are spaced by one of the two rates
    a_r1_r2_gap: assert property (@(posedge clk) disable iff (rst)
      (tick[i] && have_prev[i] && clean[i] && !cm_d[i])
        |-> (gap[i] == GW'(SLOW_DIV) || gap[i] == GW'(FAST_DIV)));

    // R6: a counter-mode tick follows a 1->0 step of the event input
    a_r6_fall_source: assert property (@(posedge clk) disable iff (rst)
      (tick[i] && cm_d[i])
        |-> ($past(ext_evt[i], SYNC_STAGES + 2) && !$past(ext_evt[i], SYNC_STAGES + 1)));
  end

  // R7: baud mode keeps timer 2 at the slow spacing
  a_r7_baud_slow: assert property (@(posedge clk) disable iff (rst)
    (tick[BAUD_TIMER] && have_prev[BAUD_TIMER] && clean[BAUD_TIMER]
       && baud_ok && !cm_d[BAUD_TIMER]) |-> gap[BAUD_TIMER] == GW'(SLOW_DIV));

  // R3 / R8: a read following a write returns the stored bits, reserved as 0
  a_r3_readback: assert property (@(posedge clk) disable iff (rst)
    ($past(wmatch) && (sfr_addr == CTRL_ADDR) && !sfr_wr) |=> (sfr_rdata == wd_q));
endmodule

bind timer_tick_gen ttg_checker #(
  .NUM_TIMERS (NUM_TIMERS),
  .SLOW_DIV   (SLOW_DIV),
  .FAST_DIV   (FAST_DIV),
  .SYNC_STAGES(SYNC_STAGES),
  .ADDR_W     (ADDR_W),
  .CTRL_ADDR  (CTRL_ADDR)
) u_chk (.*);

// File: tb/timer_tick_gen_test.sv
`timescale 1ns/1ps
module timer_tick_gen_test;
  localparam logic [7:0] CA = 8'h8E;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = CA;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;
  logic [2:0] cnt_mode = '0;
  logic       t2_baud = 1'b0;
  logic [2:0] ext_evt = 3'b111;
  logic [2:0] tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  timer_tick_gen uut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .cnt_mode(cnt_mode),
    .t2_baud(t2_baud), .ext_evt(ext_evt), .tick(tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = CA;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    sfr_addr = a;
    @(negedge clk);
    v = sfr_rdata;
  endtask

  task automatic wait_tick(input int i, input string req);
    int g = 0;
    do begin @(negedge clk); g++; end while (!tick[i] && g < 200);
    if (g >= 200) chk({req, " timeout"}, 0, 1);
  endtask

  task automatic gap(input int i, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[i] && n < 200);
  endtask

  task automatic t_reset();
    int v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 tick at reset", tick, 0);
    rst = 1'b0;
    rd(CA, v);
    chk("R5 register after reset", v, 0);
  endtask

  task automatic t_legacy();
    int n;
    for (int i = 0; i < 3; i++) begin
      wait_tick(i, "R1");
      gap(i, n);
      chk($sformatf("R1 timer%0d slow gap", i), n, 12);
    end
    wait_tick(1, "R10");
    @(negedge clk);
    chk("R10 pulse width", tick[1], 0);
  endtask

  task automatic t_switch();
    int n;
    wait_tick(0, "R9");
    sfr_addr = CA; sfr_wdata = 8'h08; sfr_wr = 1'b1;
    n = 0;
    do begin @(negedge clk); sfr_wr = 1'b0; n++; end while (!tick[0] && n < 200);
    chk("R9 interval in flight keeps old rate", n, 12);
    gap(0, n);
    chk("R2 fast gap after switch", n, 4);
  endtask

  task automatic t_independent();
    int n;
    wait_tick(1, "R4");
    gap(1, n); chk("R4 timer1 slow while timer0 fast", n, 12);
    gap(1, n); chk("R4 timer1 slow second gap", n, 12);
    wait_tick(0, "R4");
    gap(0, n); chk("R2 timer0 fast gap", n, 4);
  endtask

  task automatic t_counter();
    int c = 0;
    cnt_mode[0] = 1'b1;
    repeat (6) @(negedge clk);
    repeat (20) begin @(negedge clk); if (tick[0]) c++; end
    chk("R6 no internal ticks in counter mode", c, 0);
    c = 0;
    for (int k = 0; k < 5; k++) begin
      ext_evt[0] = 1'b0;
      repeat (3) begin @(negedge clk); if (tick[0]) c++; end
      ext_evt[0] = 1'b1;
      repeat (3) begin @(negedge clk); if (tick[0]) c++; end
    end
    repeat (6) begin @(negedge clk); if (tick[0]) c++; end
    chk("R6 one tick per falling edge", c, 5);
    cnt_mode[0] = 1'b0;
  endtask

  task automatic t_baud();
    int n;
    wr(CA, 8'h20);
    t2_baud = 1'b1;
    wait_tick(2, "R7"); wait_tick(2, "R7");
    gap(2, n);
    chk("R7 baud mode forces slow rate", n, 12);
    t2_baud = 1'b0;
    wait_tick(2, "R7"); wait_tick(2, "R7");
    gap(2, n);
    chk("R2 timer2 fast once baud mode ends", n, 4);
  endtask

  task automatic t_readback();
    int v;
    wr(CA, 8'hFF);
    rd(CA, v);
    chk("R8 reserved bits read 0", v, 8'h3F);
    wr(CA, 8'h05);
    rd(CA, v);
    chk("R3 low field read back", v, 8'h05);
    wr(8'h8F, 8'hFF);
    rd(CA, v);
    chk("R3 other address ignored", v, 8'h05);
  endtask

  initial begin
    #(50000 * 10);
    if (!done) begin
      chk("watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_legacy();
    t_switch();
    t_independent();
    t_counter();
    t_baud();
    t_readback();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule